// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small system-on-chip is in: operating, idle or standby. Software asks for idle or standby by writing to one of two decoded addresses. A rising edge on the dedicated wake pin or on a chosen set of keyboard port bits brings the chip back to operating. An enabled interrupt that is pending does the same from idle, and also from standby once software has entered standby itself. Two active-low hardware inputs, power-fail and user-reset, force the chip into standby. They first let any DRAM cycle in flight finish.

The block drives five outputs: the processor clock enable, the oscillator/PLL enable, an external clock-enable pin, the RUN indicator and a DRAM self-refresh request. When self-refresh is enabled, entry to standby asks the DRAM controller for self-refresh and waits for its acknowledgement before the oscillator is stopped. Leaving standby always passes through a restart phase. In that phase the oscillator runs again, and the processor clock and RUN wait for a clock-stable input.

The oscillator, PLL, DRAM controller, interrupt controller and real-time clock are outside the block. Each appears only as a level or a request/acknowledge signal.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While the active-high `rst` input is high, and at once without waiting for a clock edge, the block is in standby: `cpu_clk_en`, `osc_en`, `run` and `sref_req` are all 0. After `rst` falls the block stays in standby until a wake event.
- R2: Standby never goes straight to operating or to idle. `cpu_clk_en` is raised out of standby only after a restart phase in which `osc_en`=1 and `run`=0. In every cycle, `cpu_clk_en`=1 implies `run`=1.
- R3: Each wake input passes through a `SYNC_STAGES`-flop synchronizer (default 2), then a rising-edge detector. A rising edge on `wake_pin`, or on a `kbd_port` bit whose bit in `KBD_WAKE_MASK` is 1 (default 8'hBF: bits 0..5 and 7), starts the restart phase `SYNC_STAGES`+1 clock edges after the input rises. A rising edge on bit 6 has no effect.
- R4: In standby, `irq_pending` starts the restart phase (next edge) only if the most recent entry to standby was a software write from operating. After cold reset, or after a hardware-forced entry, `irq_pending` is ignored in standby.
- R5: A bus write (`bus_wr`=1) to address `IDLE_ADDR` while operating enters idle at that edge: `cpu_clk_en`=0, while `osc_en` and `run` stay 1.
- R6: In idle, `irq_pending`=1 or a wake edge returns the block to operating: `cpu_clk_en`=1.
- R7: A bus write to `STBY_ADDR` while operating leads to standby, where `cpu_clk_en`, `osc_en` and `run` are 0. Without self-refresh this happens at that edge.
- R8: `clken_pin` is 0 only when the oscillator is stopped in standby with `mode_13m`=1 and `clken_sel`=0. In every other case it is 1.
- R9: With `sref_en`=1, every entry to standby first raises `sref_req` with `osc_en` still 1. It stays there until `sref_ack`=1, and standby is entered on the edge after that. `sref_req` then stays 1 through standby and the restart phase. With `sref_en`=0, `sref_req` stays 0.
- R10: `pwr_fail_n`=0 or `user_reset_n`=0 forces standby from operating or idle. It takes effect `SYNC_STAGES`+1 edges after the input falls, through a drain phase that holds while `dram_busy`=1. The sequence then continues as in R7/R9. While either input is low in standby, no wake source has any effect.
- R11: Writes to any other address are ignored. An idle or standby write is also ignored when the block is not operating.
- R12: In the restart phase `osc_en`=1, `run`=0 and `cpu_clk_en`=0 while `clk_stable`=0. On the edge after `clk_stable`=1, `cpu_clk_en` and `run` rise and `sref_req` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Cold reset, active high, asynchronous assertion |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| wake_pin | input | 1 | Dedicated wake input, rising edge wakes |
| kbd_port | input | KBD_W | Keyboard port bits, masked rising edges wake |
| irq_pending | input | 1 | An enabled interrupt is pending |
| pwr_fail_n | input | 1 | Power-fail, active low, forces standby |
| user_reset_n | input | 1 | User reset, active low, forces standby |
| dram_busy | input | 1 | A DRAM cycle is in progress |
| sref_en | input | 1 | DRAM self-refresh is enabled |
| sref_ack | input | 1 | DRAM controller is in self-refresh |
| clk_stable | input | 1 | Restarted oscillator/PLL is stable |
| mode_13m | input | 1 | 1: external 13 MHz clock, 0: internal 18.432 MHz PLL |
| clken_sel | input | 1 | Clock-enable pin behaviour select for 13 MHz mode |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_en | output | 1 | Main oscillator/PLL enable |
| clken_pin | output | 1 | External oscillator enable pin |
| run | output | 1 | System running indicator |
| sref_req | output | 1 | DRAM self-refresh request |

## Verification
The wake logic is driven with four kinds of wake input: a rising edge on the masked-out port bit 6, edges on enabled port bits 0, 3 and 7, the wake pin, and a pending interrupt. The bit 6 case separates the mask from a plain OR of the port. The interrupt is applied both after a software standby entry and after a hardware-forced one, which shows whether the arming flag is tracked. Standby is entered three ways: by software with self-refresh on, by software with it off, and by each hardware input, with DRAM busy and with it idle. Holding `dram_busy`, `sref_ack` and `clk_stable` low for several cycles shows that each phase waits for its handshake and does not fall through after a fixed delay.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_STANDBY = 3'd0,
        PM_RESTART = 3'd1,
        PM_OPER    = 3'd2,
        PM_IDLE    = 3'd3,
        PM_DRAIN   = 3'd4,
        PM_SREF    = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic osc_en;
        logic run;
        logic sref_req;
        logic clocks_off;
    } pm_out_t;

    // Output levels are a pure function of the mode and the held
    // self-refresh flag.
    function automatic pm_out_t pm_outputs(pm_state_e st, logic sref_held);
        pm_out_t o;
        o = '0;
        case (st)
            PM_OPER: begin
                o.cpu_clk_en = 1'b1;
                o.osc_en     = 1'b1;
                o.run        = 1'b1;
            end
            PM_IDLE, PM_DRAIN: begin
                o.osc_en = 1'b1;
                o.run    = 1'b1;
            end
            PM_SREF: begin
                o.osc_en   = 1'b1;
                o.run      = 1'b1;
                o.sref_req = 1'b1;
            end
            PM_RESTART: begin
                o.osc_en   = 1'b1;
                o.sref_req = sref_held;
            end
            default: begin
                o.sref_req   = sref_held;
                o.clocks_off = 1'b1;
            end
        endcase
        return o;
    endfunction

    // The external enable pin is pulled low only in 13 MHz mode with the
    // select bit clear, and only while clocks are stopped.
    function automatic logic pm_clken_level(logic clocks_off, logic mode_13m,
                                            logic clken_sel);
        return !(clocks_off && mode_13m && !clken_sel);
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int               KBD_W         = 8,
    parameter logic [KBD_W-1:0] KBD_WAKE_MASK = 8'hBF,
    parameter int               SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wake_pin,
    input  logic [KBD_W-1:0] kbd_port,
    output logic             wake_evt
);
    localparam int SRC_W = KBD_W + 1;

    logic [SRC_W-1:0] raw;
    logic [SRC_W-1:0] synced;
    logic [SRC_W-1:0] prev_q;
    logic [SRC_W-1:0] rise;
    logic [KBD_W-1:0] kbd_hit;

    assign raw = {kbd_port, wake_pin};

    pwr_sync #(
        .WIDTH  (SRC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('0)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw),
        .dout(synced)
    );

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev_q <= '0;
        else     prev_q <= synced;
    end

    assign rise = synced & ~prev_q;

    for (genvar i = 0; i < KBD_W; i++) begin : g_kbd
        if (KBD_WAKE_MASK[i]) begin : g_on
            assign kbd_hit[i] = rise[i+1];
        end else begin : g_off
            assign kbd_hit[i] = 1'b0;
        end
    end

    assign wake_evt = rise[0] | (|kbd_hit);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_mode_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] IDLE_ADDR = 16'h0800,
    parameter logic [ADDR_W-1:0] STBY_ADDR = 16'h0840
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wake_evt,
    input  logic              irq_pending,
    input  logic              hw_force,
    input  logic              dram_busy,
    input  logic              sref_en,
    input  logic              sref_ack,
    input  logic              clk_stable,
    output pm_state_e         state,
    output logic              sref_held
);
    pm_state_e state_q, state_d;
    logic      armed_q, armed_d;
    logic      held_q, held_d;
    logic      wr_idle, wr_stby;
    pm_state_e stop_target;

    assign wr_idle = bus_wr && (bus_addr == IDLE_ADDR);
    assign wr_stby = bus_wr && (bus_addr == STBY_ADDR);

    // Where a standby entry goes once DRAM is quiet.
    assign stop_target = sref_en ? PM_SREF : PM_STANDBY;

    always_comb begin
        state_d = state_q;
        armed_d = armed_q;
        held_d  = held_q;
        case (state_q)
            PM_OPER: begin
                if (hw_force) begin
                    state_d = PM_DRAIN;
                    armed_d = 1'b0;
                end else if (wr_stby) begin
                    state_d = stop_target;
                    armed_d = 1'b1;
                end else if (wr_idle) begin
                    state_d = PM_IDLE;
                end
            end
            PM_IDLE: begin
                if (hw_force) begin
                    state_d = PM_DRAIN;
                    armed_d = 1'b0;
                end else if (wake_evt || irq_pending) begin
                    state_d = PM_OPER;
                end
            end
            PM_DRAIN: begin
                if (!dram_busy) state_d = stop_target;
            end
            PM_SREF: begin
                if (sref_ack) begin
                    state_d = PM_STANDBY;
                    held_d  = 1'b1;
                end
            end
            PM_STANDBY: begin
                if (!hw_force && (wake_evt || (armed_q && irq_pending)))
                    state_d = PM_RESTART;
            end
            PM_RESTART: begin
                if (clk_stable) begin
                    state_d = PM_OPER;
                    held_d  = 1'b0;
                end
            end
            default: state_d = PM_STANDBY;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= PM_STANDBY;
            armed_q <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
            held_q  <= held_d;
        end
    end

    assign state     = state_q;
    assign sref_held = held_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int                ADDR_W        = 16,
    parameter logic [ADDR_W-1:0] IDLE_ADDR     = 16'h0800,
    parameter logic [ADDR_W-1:0] STBY_ADDR     = 16'h0840,
    parameter int                KBD_W         = 8,
    parameter logic [KBD_W-1:0]  KBD_WAKE_MASK = 8'hBF,
    parameter int                SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              wake_pin,
    input  logic [KBD_W-1:0]  kbd_port,
    input  logic              irq_pending,
    input  logic              pwr_fail_n,
    input  logic              user_reset_n,
    input  logic              dram_busy,
    input  logic              sref_en,
    input  logic              sref_ack,
    input  logic              clk_stable,
    input  logic              mode_13m,
    input  logic              clken_sel,
    output logic              cpu_clk_en,
    output logic              osc_en,
    output logic              clken_pin,
    output logic              run,
    output logic              sref_req
);
    localparam logic [1:0] FORCE_IDLE = 2'b11;

    logic      wake_evt;
    logic [1:0] force_sync;
    logic      hw_force;
    pm_state_e cur_state;
    logic      sref_held;
    pm_out_t   outs;

    pwr_wake_detect #(
        .KBD_W        (KBD_W),
        .KBD_WAKE_MASK(KBD_WAKE_MASK),
        .SYNC_STAGES  (SYNC_STAGES)
    ) u_wake (
        .clk     (clk),
        .rst     (rst),
        .wake_pin(wake_pin),
        .kbd_port(kbd_port),
        .wake_evt(wake_evt)
    );

    pwr_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(FORCE_IDLE)
    ) u_force_sync (
        .clk (clk),
        .rst (rst),
        .din ({pwr_fail_n, user_reset_n}),
        .dout(force_sync)
    );

    assign hw_force = (force_sync != FORCE_IDLE);

    pwr_fsm #(
        .ADDR_W   (ADDR_W),
        .IDLE_ADDR(IDLE_ADDR),
        .STBY_ADDR(STBY_ADDR)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .wake_evt   (wake_evt),
        .irq_pending(irq_pending),
        .hw_force   (hw_force),
        .dram_busy  (dram_busy),
        .sref_en    (sref_en),
        .sref_ack   (sref_ack),
        .clk_stable (clk_stable),
        .state      (cur_state),
        .sref_held  (sref_held)
    );

    assign outs       = pm_outputs(cur_state, sref_held);
    assign cpu_clk_en = outs.cpu_clk_en;
    assign osc_en     = outs.osc_en;
    assign run        = outs.run;
    assign sref_req   = outs.sref_req;
    assign clken_pin  = pm_clken_level(outs.clocks_off, mode_13m, clken_sel);
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
    import pwr_mode_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input pm_state_e cur_state,
    input logic      cpu_clk_en,
    input logic      osc_en,
    input logic      run,
    input logic      clken_pin,
    input logic      sref_en,
    input logic      sref_ack,
    input logic      dram_busy,
    input logic      clk_stable
);
    // R2
    stby_exit_chk: assert property (@(posedge clk) disable iff (rst)
        cur_state == PM_STANDBY |=> (cur_state == PM_STANDBY || cur_state == PM_RESTART));

    // R2
    cpu_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> run);

    // R5
    idle_osc_chk: assert property (@(posedge clk) disable iff (rst)
        cur_state == PM_IDLE |-> (osc_en && run && !cpu_clk_en));

    // R7
    stby_off_chk: assert property (@(posedge clk) disable iff (rst)
        cur_state == PM_STANDBY |-> (!run && !osc_en && !cpu_clk_en));

    // R8
    clken_awake_chk: assert property (@(posedge clk) disable iff (rst)
        cur_state != PM_STANDBY |-> clken_pin);

    // R9
    sref_first_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_state == PM_STANDBY && $past(cur_state) != PM_STANDBY && $past(sref_en))
        |-> ($past(cur_state) == PM_SREF && $past(sref_ack)));

    // R10
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_state == PM_DRAIN && dram_busy) |=> cur_state == PM_DRAIN);

    // R12
    restart_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_state == PM_RESTART && !clk_stable) |=> (cur_state == PM_RESTART && !run));
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cur_state (cur_state),
    .cpu_clk_en(cpu_clk_en),
    .osc_en    (osc_en),
    .run       (run),
    .clken_pin (clken_pin),
    .sref_en   (sref_en),
    .sref_ack  (sref_ack),
    .dram_busy (dram_busy),
    .clk_stable(clk_stable)
);

// File: tb/pwr_mode_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_bench;
    localparam logic [15:0] A_IDLE = 16'h0800;
    localparam logic [15:0] A_STBY = 16'h0840;

    // observed outputs packed as {cpu_clk_en, osc_en, run, sref_req}
    localparam logic [3:0] O_OPER    = 4'b1110;
    localparam logic [3:0] O_IDLE    = 4'b0110;
    localparam logic [3:0] O_SREF    = 4'b0111;
    localparam logic [3:0] O_STBY    = 4'b0000;
    localparam logic [3:0] O_STBY_SR = 4'b0001;
    localparam logic [3:0] O_RST     = 4'b0100;
    localparam logic [3:0] O_RST_SR  = 4'b0101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        wake_pin = 1'b0;
    logic [7:0]  kbd_port = '0;
    logic        irq_pending = 1'b0;
    logic        pwr_fail_n = 1'b1;
    logic        user_reset_n = 1'b1;
    logic        dram_busy = 1'b0;
    logic        sref_en = 1'b0;
    logic        sref_ack = 1'b0;
    logic        clk_stable = 1'b0;
    logic        mode_13m = 1'b1;
    logic        clken_sel = 1'b0;
    logic        cpu_clk_en, osc_en, clken_pin, run, sref_req;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl u_pwr_mode_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .wake_pin(wake_pin), .kbd_port(kbd_port), .irq_pending(irq_pending),
        .pwr_fail_n(pwr_fail_n), .user_reset_n(user_reset_n),
        .dram_busy(dram_busy), .sref_en(sref_en), .sref_ack(sref_ack),
        .clk_stable(clk_stable), .mode_13m(mode_13m), .clken_sel(clken_sel),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en), .clken_pin(clken_pin),
        .run(run), .sref_req(sref_req)
    );

    wire [3:0] obs = {cpu_clk_en, osc_en, run, sref_req};

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check4(input string req, input logic [3:0] exp);
        n_checks++;
        if (obs !== exp) begin
            n_err++;
            $display("FAIL %s: {cpu,osc,run,sref} actual=%b expected=%b", req, obs, exp);
        end
    endtask

    task automatic check1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] addr);
        bus_addr = addr;
        bus_wr   = 1'b1;
        tick(1);
        bus_wr   = 1'b0;
    endtask

    // restart phase to operating
    task automatic finish_restart(input logic [3:0] exp_restart);
        check4("R12 restart phase", exp_restart);
        tick(4);
        check4("R12 waits for clk_stable", exp_restart);
        clk_stable = 1'b1;
        tick(1);
        check4("R12 R2 operating after stable", O_OPER);
        clk_stable = 1'b0;
    endtask

    task automatic t_cold_reset;
        tick(3);
        check4("R1 outputs during reset", O_STBY);
        rst = 1'b0;
        tick(2);
        check4("R1 standby after release", O_STBY);
        check1("R8 clken low 13M sel=0", clken_pin, 1'b0);
        irq_pending = 1'b1;
        tick(6);
        check4("R4 irq ignored after cold reset", O_STBY);
        irq_pending = 1'b0;
        kbd_port[6] = 1'b1;
        tick(6);
        check4("R3 bit6 does not wake", O_STBY);
    endtask

    task automatic t_kbd_wake;
        kbd_port[3] = 1'b1;
        tick(2);
        check4("R3 no wake before sync latency", O_STBY);
        tick(1);
        finish_restart(O_RST);
        kbd_port = '0;
        tick(3);
    endtask

    task automatic t_idle;
        bus_write(16'h0804);
        check4("R11 other address ignored", O_OPER);
        bus_write(A_IDLE);
        check4("R5 idle entered", O_IDLE);
        bus_write(A_STBY);
        check4("R11 standby write ignored in idle", O_IDLE);
        irq_pending = 1'b1;
        tick(1);
        check4("R6 irq leaves idle", O_OPER);
        irq_pending = 1'b0;
        bus_write(A_IDLE);
        check4("R5 idle again", O_IDLE);
        wake_pin = 1'b1;
        tick(3);
        check4("R6 wake pin leaves idle", O_OPER);
        wake_pin = 1'b0;
        tick(3);
    endtask

    task automatic t_sw_stby_sref;
        sref_en = 1'b1;
        bus_write(A_STBY);
        check4("R9 sref request before stop", O_SREF);
        tick(4);
        check4("R9 osc held until ack", O_SREF);
        sref_ack = 1'b1;
        tick(1);
        check4("R7 R9 standby with sref held", O_STBY_SR);
        sref_ack = 1'b0;
        check1("R8 clken low 13M sel=0", clken_pin, 1'b0);
        clken_sel = 1'b1;
        #1;
        check1("R8 clken high 13M sel=1", clken_pin, 1'b1);
        mode_13m = 1'b0;
        clken_sel = 1'b0;
        #1;
        check1("R8 clken high PLL mode", clken_pin, 1'b1);
        mode_13m = 1'b1;
        tick(1);
        irq_pending = 1'b1;
        tick(1);
        irq_pending = 1'b0;
        finish_restart(O_RST_SR);
    endtask

    task automatic t_hw_force_busy;
        dram_busy  = 1'b1;
        pwr_fail_n = 1'b0;
        tick(2);
        check4("R10 force not yet seen", O_OPER);
        tick(1);
        check4("R10 drain phase", O_IDLE);
        tick(5);
        check4("R10 drain holds while busy", O_IDLE);
        dram_busy = 1'b0;
        tick(1);
        check4("R10 R9 sref after drain", O_SREF);
        sref_ack = 1'b1;
        tick(1);
        sref_ack = 1'b0;
        check4("R10 standby reached", O_STBY_SR);
        wake_pin = 1'b1;
        irq_pending = 1'b1;
        tick(6);
        check4("R10 R4 no wake while forced", O_STBY_SR);
        pwr_fail_n = 1'b1;
        tick(5);
        check4("R4 irq ignored after forced entry", O_STBY_SR);
        irq_pending = 1'b0;
        wake_pin = 1'b0;
        tick(4);
        wake_pin = 1'b1;
        tick(3);
        finish_restart(O_RST_SR);
        wake_pin = 1'b0;
        tick(3);
    endtask

    task automatic t_user_reset_idle;
        sref_en = 1'b0;
        bus_write(A_IDLE);
        check4("R5 idle before force", O_IDLE);
        user_reset_n = 1'b0;
        tick(4);
        check4("R10 R9 user reset to standby no sref", O_STBY);
        user_reset_n = 1'b1;
        tick(4);
        kbd_port[7] = 1'b1;
        tick(3);
        finish_restart(O_RST);
        kbd_port = '0;
        tick(3);
    endtask

    task automatic t_sw_stby_plain;
        bus_write(A_STBY);
        check4("R7 standby at write edge", O_STBY);
        kbd_port[6] = 1'b1;
        tick(6);
        check4("R3 bit6 ignored in standby", O_STBY);
        kbd_port[0] = 1'b1;
        tick(3);
        finish_restart(O_RST);
        kbd_port = '0;
        tick(3);
    endtask

    task automatic t_async_reset;
        rst = 1'b1;
        #1;
        check4("R1 async reset from operating", O_STBY);
        tick(2);
        rst = 1'b0;
        tick(2);
        check4("R1 standby after second reset", O_STBY);
    endtask

    initial begin
        t_cold_reset();
        t_kbd_wake();
        t_idle();
        t_sw_stby_sref();
        t_hw_force_busy();
        t_user_reset_idle();
        t_sw_stby_plain();
        t_async_reset();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        end
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        end
        $finish;
    end
endmodule